// File: doc/BRIEF.md
# Phase-Interleaved Memory Cluster Controller

This block is the memory-side end of a cluster of interleaved memory modules. The modules share one port toward the network, and each of them owns one phase of a PHASES-step rotating schedule. A free-running phase counter advances once per network cycle, which is one clock. In any cycle only the module that owns the current phase is connected. A request that names that module is taken in. A request that names any other module is dropped.

A memory cycle lasts PHASES network cycles. In that time the connected module runs a row stage and then a column stage. The controller then places the result on the return side, exactly one memory cycle after the request cycle. A write returns an acknowledge flag with the source tag. A read returns the source tag with the data word. The modules are visited in strict rotation and each holds for exactly one rotation. As a result, replies leave in the order the requests came in, and the port can take one request in every cycle without a gap.

The module storage is a plain synchronous array in each module, so block RAM can be inferred for it. The network on either side is outside the block.

Top module: `mem_cluster_ctrl`

## Requirements
- R1: `phase_o` is 0 in the first cycle after reset. It then rises by one every clock and wraps from PHASES-1 back to 0.
- R2: A request is taken only when `req_valid` is 1 and `req_bank` equals `phase_o` in that cycle. Any other request is ignored: it gives no reply, and a write that is ignored leaves the addressed word unchanged.
- R3: A request taken in cycle c gives `rsp_valid`=1 in cycle c+PHASES and in no other cycle. The port sustains one taken request per cycle.
- R4: Replies come out in the order their requests were taken, and there is at most one reply per cycle.
- R5: `rsp_src` equals the `req_src` value of the request that the reply answers.
- R6: A taken write (`req_write`=1) stores `req_wdata` at `req_addr` of module `req_bank`. Its reply has `rsp_write`=1 and `rsp_data`=0.
- R7: A taken read (`req_write`=0) gives a reply with `rsp_write`=0. Its `rsp_data` is the last value written to that module and address.
- R8: Reset sets the phase to 0, drops every access in flight and holds `rsp_valid` at 0. No reply appears for an access that was taken before reset.
- R9: Each access passes through a row stage and then a column stage before its reply. A module is never taken while an access is in progress in it, and it can be taken again in the cycle its previous reply appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Network-cycle clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_bank | input | $clog2(PHASES) | Target module index |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address inside the module |
| req_wdata | input | DATA_W | Write data |
| req_src | input | SRC_W | Source phase tag to echo |
| phase_o | output | $clog2(PHASES) | Module connected this cycle |
| rsp_valid | output | 1 | Reply present this cycle |
| rsp_write | output | 1 | Reply acknowledges a write |
| rsp_src | output | SRC_W | Echoed source tag |
| rsp_data | output | DATA_W | Read data, 0 for writes |

## Verification
If the phase counter slips, `phase_o` leaves its modulo sequence on the very next cycle. From then on, requests that should be taken are dropped, and that shows as a missing reply one rotation later. If a module's stage counter is wrong, the reply comes out a cycle early or late, which breaks the exact PHASES-cycle spacing at the reply port. If the module is taken again too soon, the reply is lost. A wrong latch of tag, flag or data is visible in the one reply that follows. A storage fault, or an ignored write that gets stored anyway, shows up the first time that address is read back.

// File: rtl/mcc_pkg.sv
package mcc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ROW  = 2'd1,
    ST_COL  = 2'd2
  } bank_st_e;
endpackage

// File: rtl/mcc_phase_gen.sv
module mcc_phase_gen #(
  parameter int PHASES = 4,
  localparam int PH_W = (PHASES > 1) ? $clog2(PHASES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  output logic [PH_W-1:0]   phase_q,
  output logic [PHASES-1:0] phase_oh
);
  localparam logic [PH_W-1:0] LAST = PH_W'(PHASES - 1);

  // binary phase index
  always_ff @(posedge clk) begin
    if (rst) phase_q <= '0;
    else if (phase_q == LAST) phase_q <= '0;
    else phase_q <= phase_q + 1'b1;
  end

  // one-hot ring used to enable module ports
  always_ff @(posedge clk) begin
    if (rst) phase_oh <= PHASES'(1);
    else phase_oh <= {phase_oh[PHASES-2:0], phase_oh[PHASES-1]};
  end
endmodule

// File: rtl/mcc_bank.sv
module mcc_bank
  import mcc_pkg::*;
#(
  parameter int PHASES = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int SRC_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [SRC_W-1:0]  src,
  output logic              busy,
  output logic              in_col,
  output logic              done_q,
  output logic              wr_q,
  output logic [SRC_W-1:0]  src_q,
  output logic [DATA_W-1:0] data_q
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = $clog2(PHASES);
  localparam logic [CNT_W-1:0] ROW_LEN = CNT_W'(PHASES / 2);
  localparam logic [CNT_W-1:0] LAST    = CNT_W'(PHASES - 1);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_q;
  bank_st_e          st;
  logic [CNT_W-1:0]  cnt;
  logic              wr_l;
  logic [SRC_W-1:0]  src_l;

  // storage: plain synchronous write and registered read
  always_ff @(posedge clk) begin
    if (acc && we) mem[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (acc && !we) rd_q <= mem[addr];
  end

  // row/column stage sequencing over one memory cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      wr_l   <= 1'b0;
      src_l  <= '0;
      done_q <= 1'b0;
      wr_q   <= 1'b0;
      src_q  <= '0;
      data_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (acc) begin
        cnt   <= ONE;
        st    <= (ONE >= ROW_LEN) ? ST_COL : ST_ROW;
        wr_l  <= we;
        src_l <= src;
      end else if (st != ST_IDLE) begin
        if (cnt == LAST) begin
          st     <= ST_IDLE;
          done_q <= 1'b1;
          wr_q   <= wr_l;
          src_q  <= src_l;
          data_q <= wr_l ? '0 : rd_q;
        end else begin
          cnt <= cnt + 1'b1;
          st  <= ((cnt + 1'b1) >= ROW_LEN) ? ST_COL : ST_ROW;
        end
      end
    end
  end

  assign busy   = (st != ST_IDLE);
  assign in_col = (st == ST_COL);
endmodule

// File: rtl/mcc_return.sv
module mcc_return #(
  parameter int PHASES = 4,
  parameter int DATA_W = 8,
  parameter int SRC_W  = 2
) (
  input  logic [PHASES-1:0]             done_vec,
  input  logic [PHASES-1:0]             wr_vec,
  input  logic [PHASES-1:0][SRC_W-1:0]  src_vec,
  input  logic [PHASES-1:0][DATA_W-1:0] data_vec,
  output logic                          rsp_valid,
  output logic                          rsp_write,
  output logic [SRC_W-1:0]              rsp_src,
  output logic [DATA_W-1:0]             rsp_data
);
  // at most one module finishes per cycle, so an AND-OR merge is enough
  always_comb begin
    rsp_valid = 1'b0;
    rsp_write = 1'b0;
    rsp_src   = '0;
    rsp_data  = '0;
    for (int i = 0; i < PHASES; i++) begin
      rsp_valid = rsp_valid | done_vec[i];
      rsp_write = rsp_write | (done_vec[i] & wr_vec[i]);
      rsp_src   = rsp_src   | ({SRC_W{done_vec[i]}} & src_vec[i]);
      rsp_data  = rsp_data  | ({DATA_W{done_vec[i]}} & data_vec[i]);
    end
  end
endmodule

// File: rtl/mem_cluster_ctrl.sv
module mem_cluster_ctrl #(
  parameter int PHASES = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int SRC_W  = 2,
  localparam int BANK_W = $clog2(PHASES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [BANK_W-1:0] req_bank,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [SRC_W-1:0]  req_src,
  output logic [BANK_W-1:0] phase_o,
  output logic              rsp_valid,
  output logic              rsp_write,
  output logic [SRC_W-1:0]  rsp_src,
  output logic [DATA_W-1:0] rsp_data
);
  logic [PHASES-1:0]             phase_oh;
  logic [PHASES-1:0]             acc_vec;
  logic [PHASES-1:0]             busy_vec;
  logic [PHASES-1:0]             col_vec;
  logic [PHASES-1:0]             done_vec;
  logic [PHASES-1:0]             wr_vec;
  logic [PHASES-1:0][SRC_W-1:0]  src_vec;
  logic [PHASES-1:0][DATA_W-1:0] data_vec;

  mcc_phase_gen #(.PHASES(PHASES)) u_phase (
    .clk      (clk),
    .rst      (rst),
    .phase_q  (phase_o),
    .phase_oh (phase_oh)
  );

  for (genvar g = 0; g < PHASES; g++) begin : g_bank
    assign acc_vec[g] = req_valid && phase_oh[g] &&
                        (req_bank == BANK_W'(g)) && !busy_vec[g];

    mcc_bank #(
      .PHASES (PHASES),
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .SRC_W  (SRC_W)
    ) u_bank (
      .clk    (clk),
      .rst    (rst),
      .acc    (acc_vec[g]),
      .we     (req_write),
      .addr   (req_addr),
      .wdata  (req_wdata),
      .src    (req_src),
      .busy   (busy_vec[g]),
      .in_col (col_vec[g]),
      .done_q (done_vec[g]),
      .wr_q   (wr_vec[g]),
      .src_q  (src_vec[g]),
      .data_q (data_vec[g])
    );
  end

  mcc_return #(
    .PHASES (PHASES),
    .DATA_W (DATA_W),
    .SRC_W  (SRC_W)
  ) u_ret (
    .done_vec  (done_vec),
    .wr_vec    (wr_vec),
    .src_vec   (src_vec),
    .data_vec  (data_vec),
    .rsp_valid (rsp_valid),
    .rsp_write (rsp_write),
    .rsp_src   (rsp_src),
    .rsp_data  (rsp_data)
  );
endmodule

// File: rtl/mcc_checker.sv
module mcc_checker #(
  parameter int PHASES = 4,
  localparam int BANK_W = $clog2(PHASES)
) (
  input logic              clk,
  input logic              rst,
  input logic [BANK_W-1:0] phase_o,
  input logic [PHASES-1:0] phase_oh,
  input logic [PHASES-1:0] acc_vec,
  input logic [PHASES-1:0] busy_vec,
  input logic [PHASES-1:0] col_vec,
  input logic [PHASES-1:0] done_vec,
  input logic              rsp_valid
);
  localparam logic [BANK_W-1:0] LAST = BANK_W'(PHASES - 1);

  // R1
  phase_step_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_o != LAST) |=> (phase_o == BANK_W'($past(phase_o) + 1'b1)));

  // R1
  phase_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_o == LAST) |=> (phase_o == '0));

  // R1
  phase_ring_chk: assert property (@(posedge clk) disable iff (rst)
    phase_oh == (PHASES'(1) << phase_o));

  // R2
  single_take_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(acc_vec));

  // R9
  take_marks_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (|acc_vec) |=> ((busy_vec & $past(acc_vec)) != '0));

  // R4
  one_reply_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(done_vec));

  // R9
  reply_after_col_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(|col_vec));

  // R8
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> !rsp_valid);
endmodule

bind mem_cluster_ctrl mcc_checker #(.PHASES(PHASES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .phase_o   (phase_o),
  .phase_oh  (phase_oh),
  .acc_vec   (acc_vec),
  .busy_vec  (busy_vec),
  .col_vec   (col_vec),
  .done_vec  (done_vec),
  .rsp_valid (rsp_valid)
);

// File: tb/tb_mem_cluster_ctrl.sv
module tb_mem_cluster_ctrl;
  localparam int W  = 4;
  localparam int NV = 16;
  localparam int NC = NV + W + 1;

  logic       clk = 1'b0;
  logic       rst;
  logic       req_valid, req_write;
  logic [1:0] req_bank, req_src;
  logic [3:0] req_addr;
  logic [7:0] req_wdata;
  logic [1:0] phase_o, rsp_src;
  logic       rsp_valid, rsp_write;
  logic [7:0] rsp_data;

  always #10 clk = ~clk;

  mem_cluster_ctrl #(.PHASES(W), .ADDR_W(4), .DATA_W(8), .SRC_W(2)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_bank(req_bank),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_src(req_src), .phase_o(phase_o), .rsp_valid(rsp_valid),
    .rsp_write(rsp_write), .rsp_src(rsp_src), .rsp_data(rsp_data)
  );

  // {valid, bank[1:0], write, addr[3:0], wdata[7:0], src[1:0]}
  localparam logic [17:0] VEC [NV] = '{
    {1'b1, 2'd0, 1'b1, 4'd3, 8'hA5, 2'd1},
    {1'b1, 2'd1, 1'b1, 4'd3, 8'h3C, 2'd2},
    {1'b1, 2'd2, 1'b1, 4'd3, 8'h81, 2'd0},
    {1'b1, 2'd3, 1'b1, 4'd0, 8'hFF, 2'd3},
    {1'b1, 2'd0, 1'b0, 4'd3, 8'h00, 2'd2},
    {1'b1, 2'd2, 1'b1, 4'd3, 8'h11, 2'd1},
    {1'b1, 2'd2, 1'b0, 4'd3, 8'h00, 2'd3},
    {1'b0, 2'd3, 1'b0, 4'd0, 8'h00, 2'd0},
    {1'b1, 2'd0, 1'b1, 4'd3, 8'h5A, 2'd0},
    {1'b1, 2'd1, 1'b0, 4'd3, 8'h00, 2'd1},
    {1'b1, 2'd3, 1'b0, 4'd0, 8'h00, 2'd2},
    {1'b1, 2'd3, 1'b0, 4'd0, 8'h00, 2'd2},
    {1'b1, 2'd0, 1'b0, 4'd3, 8'h00, 2'd3},
    {1'b1, 2'd1, 1'b1, 4'd9, 8'h77, 2'd0},
    {1'b0, 2'd0, 1'b0, 4'd0, 8'h00, 2'd0},
    {1'b1, 2'd3, 1'b1, 4'd0, 8'h00, 2'd1}
  };

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [7:0] mdl [W][16];
  logic       e_v [NC + W];
  logic       e_w [NC + W];
  logic [1:0] e_s [NC + W];
  logic [7:0] e_d [NC + W];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic idle_inputs();
    req_valid = 0; req_bank = 0; req_write = 0;
    req_addr = 0; req_wdata = 0; req_src = 0;
  endtask

  initial begin
    #(20 * 5000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    for (int i = 0; i < NC + W; i++) begin
      e_v[i] = 0; e_w[i] = 0; e_s[i] = 0; e_d[i] = 0;
    end
    rst = 1;
    idle_inputs();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 reset rsp_valid", 32'(rsp_valid), 0);
    check("R8 reset phase", 32'(phase_o), 0);
    rst = 0;

    // table walk: check outputs for this cycle, then drive this cycle's request
    for (int cyc = 0; cyc < NC; cyc++) begin
      check("R1 phase", 32'(phase_o), 32'(cyc % W));
      if (e_v[cyc]) begin
        check("R3 R9 reply present", 32'(rsp_valid), 1);
        check("R5 source echo", 32'(rsp_src), 32'(e_s[cyc]));
        check(e_w[cyc] ? "R6 write flag" : "R7 write flag", 32'(rsp_write), 32'(e_w[cyc]));
        check(e_w[cyc] ? "R6 R4 data" : "R7 R4 R2 data", 32'(rsp_data), 32'(e_d[cyc]));
      end else begin
        check("R2 R3 no reply", 32'(rsp_valid), 0);
      end
      if (cyc < NV) begin
        logic [17:0] v;
        v = VEC[cyc];
        req_valid = v[17]; req_bank = v[16:15]; req_write = v[14];
        req_addr = v[13:10]; req_wdata = v[9:2]; req_src = v[1:0];
        if (v[17] && (int'(v[16:15]) == cyc % W)) begin
          e_v[cyc + W] = 1;
          e_s[cyc + W] = v[1:0];
          e_w[cyc + W] = v[14];
          e_d[cyc + W] = v[14] ? 8'h00 : mdl[v[16:15]][v[13:10]];
          if (v[14]) mdl[v[16:15]][v[13:10]] = v[9:2];
        end
      end else begin
        idle_inputs();
      end
      @(negedge clk);
    end

    // reset while an access is in flight: the reply must never appear (R8)
    req_valid = 1; req_bank = phase_o; req_write = 0;
    req_addr = 4'd3; req_src = 2'd2;
    @(negedge clk);
    idle_inputs();
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    check("R8 phase after reset", 32'(phase_o), 0);
    for (int k = 0; k < W + 1; k++) begin
      check("R8 no stale reply", 32'(rsp_valid), 0);
      @(negedge clk);
    end

    report();
  end
endmodule